// File: doc/BRIEF.md
# Flash program/erase control register

This block is the software-visible control word of an on-chip flash controller. A 16-bit register sits on a small register bus. Software fills in an erase/program select bit and a 4-bit operation code, opens a write-enable gate, and then sets a start bit. The block decodes the select bit and the code into one operation for an external flash engine, and issues that operation as a one-cycle request. It then stays busy until the engine reports that the operation has completed or been aborted.

The start bit doubles as the busy indicator. Software can set it but cannot clear it; hardware clears it. A sequence error flag records bad start attempts and aborted operations. Several code combinations are reserved or deliberately do nothing. For those, the block accepts the start, issues no request, and drops the start bit again one cycle later.

Two resets are provided. The power-on reset clears everything. The ordinary system reset clears only the select bit and the operation code. The start bit, the write-enable gate and the error flag survive a system reset.

Top module: `flash_op_ctrl`

## Requirements
- R1: The register sits at the address held in parameter REG_ADDR. Reads there return start at bit 15, write enable at bit 14, error at bit 13, erase select at bit 6 and the code at bits 3:0. All other bits read 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R2: Power-on reset (por_n low) clears every bit, and the register reads 0. A system reset (sys_rst_n low for one clock) clears only the erase select and the code; start, write enable and error keep their values.
- R3: Software can only set the start bit. Writing 0 to bit 15 leaves a set start bit at 1. Bit 15 is not sampled when byte strobe 1 is low.
- R4: A start attempt is a write to bits 15:8 with bit 15 equal to 1. It is valid when the block is not busy and the write enable held before the write is 1. If it is valid and the decoded operation is real, req_valid is high for exactly the one cycle after the write, req_op carries the operation, and start reads 1. The attempt decodes the erase select and code that result from the same write.
- R5: With erase select 1, codes decode to the req_op encodings as follows: 1111 gives 1 (bulk erase), 1101 gives 2 (general segment erase), 1100 gives 3 (secure segment erase), 0010 gives 4 (page erase) and 0000 gives 5 (configuration byte erase).
- R6: With erase select 0, codes decode to the req_op encodings as follows: 0011 gives 6 (word program), 0001 gives 7 (row program) and 0000 gives 8 (configuration byte program). Every code not listed in R5 or R6, under either select value, decodes to 0 (no operation).
- R7: A valid start with a code that decodes to no operation issues no request. Start reads 1 for one cycle and then 0, and the error flag is left as written.
- R8: A start attempt made while busy, or while the held write enable is 0, sets the error flag. It issues no request and leaves start unchanged.
- R9: While busy with a real operation, a one-cycle eng_done clears start and the error flag. eng_done has no effect when the block is not busy.
- R10: While busy with a real operation, eng_abort clears start and sets the error flag. If both eng_abort and eng_done are high, eng_abort wins.
- R11: While start is 1, writes to the erase select and code fields are ignored.
- R12: A write to bits 15:8 loads write enable from bit 14 and the error flag from bit 13. When hardware sets or clears the error flag in the same cycle, the hardware action wins.
- R13: Byte strobe 0 enables writes to bits 7:0 (erase select and code). Byte strobe 1 enables writes to bits 15:8 (start, write enable and error).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears erase select and code only |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte strobes; bit 0 selects bits 7:0, bit 1 selects bits 15:8 |
| bus_rdata | output | 16 | Read data (combinational from the address) |
| req_valid | output | 1 | One-cycle operation request to the flash engine |
| req_op | output | 4 | Decoded operation carried with req_valid |
| eng_done | input | 1 | Engine reports normal completion |
| eng_abort | input | 1 | Engine reports that the operation was terminated |

## Verification
The hardest condition to reach is a write that lands while the block is busy. In that case the ignored field lanes, the sticky start bit and the error set all act in the same cycle, and the error set must override the error value being written. The stimulus gets there by issuing a real operation and keeping the engine responses quiet, so the block stays busy. Further writes and start attempts are then issued before done or abort is pulsed. A sweep of all 32 select/code combinations, each closed by a done pulse when it issues a request, covers the decode, including the reserved and no-operation codes and the one-cycle busy they produce.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

    localparam int DATA_W    = 16;
    localparam int BE_W      = DATA_W / 8;
    localparam int CODE_W    = 4;
    localparam int OPSEL_W   = 4;

    localparam int START_BIT = 15;
    localparam int WEN_BIT   = 14;
    localparam int ERR_BIT   = 13;
    localparam int ERASE_BIT = 6;

    typedef enum logic [OPSEL_W-1:0] {
        OP_NONE       = 4'd0,
        OP_BULK_ERASE = 4'd1,
        OP_GSEG_ERASE = 4'd2,
        OP_SSEG_ERASE = 4'd3,
        OP_PAGE_ERASE = 4'd4,
        OP_CFG_ERASE  = 4'd5,
        OP_WORD_PROG  = 4'd6,
        OP_ROW_PROG   = 4'd7,
        OP_CFG_PROG   = 4'd8
    } flash_op_e;

    typedef struct packed {
        logic              start;
        logic              wen;
        logic              err;
        logic              erase;
        logic [CODE_W-1:0] code;
        logic              nop_pend;
        logic              req_valid;
        flash_op_e         req_op;
    } ctl_state_t;

endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
    import flash_op_pkg::*;
(
    input  logic              erase_sel,
    input  logic [CODE_W-1:0] code,
    output flash_op_e         op
);

    always_comb begin
        op = OP_NONE;
        if (erase_sel) begin
            case (code)
                4'b1111: op = OP_BULK_ERASE;
                4'b1101: op = OP_GSEG_ERASE;
                4'b1100: op = OP_SSEG_ERASE;
                4'b0010: op = OP_PAGE_ERASE;
                4'b0000: op = OP_CFG_ERASE;
                default: op = OP_NONE;
            endcase
        end else begin
            case (code)
                4'b0011: op = OP_WORD_PROG;
                4'b0001: op = OP_ROW_PROG;
                4'b0000: op = OP_CFG_PROG;
                default: op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/flash_op_busif.sv
module flash_op_busif
    import flash_op_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(2)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              st_start,
    input  logic              st_wen,
    input  logic              st_err,
    input  logic              st_erase,
    input  logic [CODE_W-1:0] st_code,
    output logic              lane_hi,
    output logic              lane_lo,
    output logic              set_req,
    output logic              wd_wen,
    output logic              wd_err,
    output logic              wd_erase,
    output logic [CODE_W-1:0] wd_code,
    output logic [DATA_W-1:0] bus_rdata
);

    logic              hit;
    logic [BE_W-1:0]   lane_wr;
    logic              unused_wd;

    assign hit = (bus_addr == REG_ADDR);

    for (genvar gi = 0; gi < BE_W; gi++) begin : g_lane
        assign lane_wr[gi] = hit && bus_wr && bus_be[gi];
    end

    assign lane_lo  = lane_wr[0];
    assign lane_hi  = lane_wr[BE_W-1];
    assign set_req  = lane_hi && bus_wdata[START_BIT];
    assign wd_wen   = bus_wdata[WEN_BIT];
    assign wd_err   = bus_wdata[ERR_BIT];
    assign wd_erase = bus_wdata[ERASE_BIT];
    assign wd_code  = bus_wdata[CODE_W-1:0];
    assign unused_wd = ^{bus_wdata[ERR_BIT-1:ERASE_BIT+1], bus_wdata[ERASE_BIT-1:CODE_W]};

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[START_BIT]    = st_start;
            bus_rdata[WEN_BIT]      = st_wen;
            bus_rdata[ERR_BIT]      = st_err;
            bus_rdata[ERASE_BIT]    = st_erase;
            bus_rdata[CODE_W-1:0]   = st_code;
        end
    end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_op_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              lane_hi,
    input  logic              lane_lo,
    input  logic              set_req,
    input  logic              wd_wen,
    input  logic              wd_err,
    input  logic              wd_erase,
    input  logic [CODE_W-1:0] wd_code,
    input  logic              eng_done,
    input  logic              eng_abort,
    input  flash_op_e         dec_op,
    output logic              fld_erase_d,
    output logic [CODE_W-1:0] fld_code_d,
    output logic              start_q,
    output logic              wen_q,
    output logic              err_q,
    output logic              erase_q,
    output logic [CODE_W-1:0] code_q,
    output logic              req_valid_q,
    output flash_op_e         req_op_q
);

    ctl_state_t s_d, s_q;

    // Field lanes: locked while busy, cleared by the system reset.
    always_comb begin
        fld_erase_d = s_q.erase;
        fld_code_d  = s_q.code;
        if (lane_lo && !s_q.start) begin
            fld_erase_d = wd_erase;
            fld_code_d  = wd_code;
        end
        if (!sys_rst_n) begin
            fld_erase_d = 1'b0;
            fld_code_d  = '0;
        end
    end

    always_comb begin
        s_d           = s_q;
        s_d.erase     = fld_erase_d;
        s_d.code      = fld_code_d;
        s_d.req_valid = 1'b0;
        s_d.req_op    = OP_NONE;

        if (lane_hi) begin
            s_d.wen = wd_wen;
            s_d.err = wd_err;
        end

        if (s_q.start) begin
            if (s_q.nop_pend) begin
                s_d.start    = 1'b0;
                s_d.nop_pend = 1'b0;
            end else if (eng_abort) begin
                s_d.start = 1'b0;
                s_d.err   = 1'b1;
            end else if (eng_done) begin
                s_d.start = 1'b0;
                s_d.err   = 1'b0;
            end
        end

        if (set_req) begin
            if (s_q.start || !s_q.wen) begin
                s_d.err = 1'b1;
            end else begin
                s_d.start = 1'b1;
                if (dec_op == OP_NONE) begin
                    s_d.nop_pend = 1'b1;
                end else begin
                    s_d.req_valid = 1'b1;
                    s_d.req_op    = dec_op;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_q     = s_q.start;
    assign wen_q       = s_q.wen;
    assign err_q       = s_q.err;
    assign erase_q     = s_q.erase;
    assign code_q      = s_q.code;
    assign req_valid_q = s_q.req_valid;
    assign req_op_q    = s_q.req_op;

    // R4
    req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        req_valid_q |=> !req_valid_q);

    // R4
    req_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        req_valid_q |-> (start_q && req_op_q != OP_NONE));

    // R8
    improper_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        (set_req && (start_q || !wen_q)) |=> (err_q && !req_valid_q));

    // R10
    abort_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        (start_q && !s_q.nop_pend && eng_abort) |=> (err_q && !start_q));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (start_q && sys_rst_n) |=> ($stable(erase_q) && $stable(code_q)));

    // R7
    nop_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        s_q.nop_pend |=> (!start_q && !req_valid_q));

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_op_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(2)
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sys_rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]    bus_be,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               req_valid,
    output logic [OPSEL_W-1:0] req_op,
    input  logic               eng_done,
    input  logic               eng_abort
);

    logic              lane_hi, lane_lo, set_req;
    logic              wd_wen, wd_err, wd_erase;
    logic [CODE_W-1:0] wd_code;
    logic              fld_erase_d;
    logic [CODE_W-1:0] fld_code_d;
    logic              start_q, wen_q, err_q, erase_q;
    logic [CODE_W-1:0] code_q;
    flash_op_e         dec_op;
    flash_op_e         req_op_q;

    flash_op_busif #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) busif_i (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .st_start  (start_q),
        .st_wen    (wen_q),
        .st_err    (err_q),
        .st_erase  (erase_q),
        .st_code   (code_q),
        .lane_hi   (lane_hi),
        .lane_lo   (lane_lo),
        .set_req   (set_req),
        .wd_wen    (wd_wen),
        .wd_err    (wd_err),
        .wd_erase  (wd_erase),
        .wd_code   (wd_code),
        .bus_rdata (bus_rdata)
    );

    flash_op_decode decode_i (
        .erase_sel (fld_erase_d),
        .code      (fld_code_d),
        .op        (dec_op)
    );

    flash_op_seq seq_i (
        .clk         (clk),
        .por_n       (por_n),
        .sys_rst_n   (sys_rst_n),
        .lane_hi     (lane_hi),
        .lane_lo     (lane_lo),
        .set_req     (set_req),
        .wd_wen      (wd_wen),
        .wd_err      (wd_err),
        .wd_erase    (wd_erase),
        .wd_code     (wd_code),
        .eng_done    (eng_done),
        .eng_abort   (eng_abort),
        .dec_op      (dec_op),
        .fld_erase_d (fld_erase_d),
        .fld_code_d  (fld_code_d),
        .start_q     (start_q),
        .wen_q       (wen_q),
        .err_q       (err_q),
        .erase_q     (erase_q),
        .code_q      (code_q),
        .req_valid_q (req_valid),
        .req_op_q    (req_op_q)
    );

    assign req_op = req_op_q;

endmodule

// File: tb/flash_op_ctrl_tb_top.sv
module flash_op_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam logic [ADDR_W-1:0] REG = 4'h2;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              sys_rst_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = REG;
    logic              bus_wr = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [1:0]        bus_be = '0;
    logic [15:0]       bus_rdata;
    logic              req_valid;
    logic [3:0]        req_op;
    logic              eng_done = 1'b0;
    logic              eng_abort = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int last_req, last_op;
    logic [15:0] rv;

    // reference model state
    int m_start = 0, m_wen = 0, m_err = 0, m_ers = 0, m_code = 0, m_nop = 0;
    int m_req = 0, m_op = 0;

    flash_op_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG)) dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_op(req_op),
        .eng_done(eng_done), .eng_abort(eng_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_dec(int e, int c);
        if (e != 0) begin
            case (c)
                15: return 1;
                13: return 2;
                12: return 3;
                2:  return 4;
                0:  return 5;
                default: return 0;
            endcase
        end
        case (c)
            3: return 6;
            1: return 7;
            0: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_start = 0; m_wen = 0; m_err = 0; m_ers = 0; m_code = 0;
            m_nop = 0; m_req = 0; m_op = 0;
        end else begin
            int hit, hi, lo, busy, d;
            hit  = (bus_wr && bus_addr == REG) ? 1 : 0;
            hi   = hit && bus_be[1];
            lo   = hit && bus_be[0];
            busy = m_start;
            m_req = 0; m_op = 0;
            if (lo && !busy) begin
                m_ers  = bus_wdata[6];
                m_code = int'(bus_wdata[3:0]);
            end
            if (!sys_rst_n) begin m_ers = 0; m_code = 0; end
            d = m_wen;
            if (hi) begin m_wen = bus_wdata[14]; m_err = bus_wdata[13]; end
            if (busy) begin
                if (m_nop) begin m_start = 0; m_nop = 0; end
                else if (eng_abort) begin m_start = 0; m_err = 1; end
                else if (eng_done) begin m_start = 0; m_err = 0; end
            end
            if (hi && bus_wdata[15]) begin
                if (busy || !d) m_err = 1;
                else begin
                    m_start = 1;
                    if (ref_dec(m_ers, m_code) == 0) m_nop = 1;
                    else begin m_req = 1; m_op = ref_dec(m_ers, m_code); end
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!finished) begin
            int exp_rd;
            exp_rd = (bus_addr == REG) ?
                ((m_start << 15) | (m_wen << 14) | (m_err << 13) | (m_ers << 6) | m_code) : 0;
            chk("R1", int'(bus_rdata), exp_rd);
            chk("R4", int'(req_valid), m_req);
            chk("R5", int'(req_op), m_op);
        end
    end

    task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d, logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        last_req = int'(req_valid);
        last_op  = int'(req_op);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; bus_addr = REG;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = REG;
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); eng_abort = 1'b1;
        @(negedge clk); eng_abort = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd(REG, rv); chk("R2", int'(rv), 16'h0000);
        por_n = 1'b1;
        @(negedge clk);

        // start with wen held 0 is improper; unimplemented bits read 0
        wr(REG, 16'hFFFF, 2'b11);
        rd(REG, rv); chk("R8", int'(rv), 16'h604F);
        chk("R8", last_req, 0);
        chk("R1", int'(rv) & 16'h1FB0, 0);

        wr(REG, 16'h4000, 2'b10);
        rd(REG, rv); chk("R12", int'(rv), 16'h404F);

        // bulk erase
        wr(REG, 16'hC04F, 2'b11);
        chk("R4", last_req, 1);
        chk("R5", last_op, 1);
        rd(REG, rv); chk("R4", int'(rv), 16'hC04F);

        wr(REG, 16'h0003, 2'b01);
        rd(REG, rv); chk("R11", int'(rv), 16'hC04F);
        wr(REG, 16'h4000, 2'b10);
        rd(REG, rv); chk("R3", int'(rv), 16'hC04F);

        pulse_done();
        rd(REG, rv); chk("R9", int'(rv), 16'h404F);

        wr(REG, 16'h6000, 2'b10);
        pulse_done();
        rd(REG, rv); chk("R9", int'(rv), 16'h604F);

        // bit 15 without the high strobe does not start
        wr(REG, 16'h8003, 2'b01);
        chk("R3", last_req, 0);
        rd(REG, rv); chk("R13", int'(rv), 16'h6003);

        // word program, then improper attempt while busy, then abort
        wr(REG, 16'hC000, 2'b10);
        chk("R6", last_req, 1);
        chk("R6", last_op, 6);
        rd(REG, rv); chk("R6", int'(rv), 16'hC003);
        wr(REG, 16'hC000, 2'b10);
        chk("R8", last_req, 0);
        rd(REG, rv); chk("R12", int'(rv), 16'hE003);
        pulse_abort();
        rd(REG, rv); chk("R10", int'(rv), 16'h6003);

        // no-operation code
        wr(REG, 16'hC041, 2'b11);
        chk("R7", last_req, 0);
        rd(REG, rv); chk("R7", int'(rv), 16'hC041);
        @(posedge clk); @(negedge clk);
        rd(REG, rv); chk("R7", int'(rv), 16'h4041);

        // reserved code
        wr(REG, 16'hC04E, 2'b11);
        chk("R7", last_req, 0);
        @(posedge clk); @(negedge clk);

        // other address
        rd(REG ^ 4'h1, rv); chk("R1", int'(rv), 0);
        wr(REG ^ 4'h1, 16'hC04F, 2'b11);
        chk("R1", last_req, 0);
        rd(REG, rv); chk("R1", int'(rv), 16'h404E);

        // full decode sweep
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 16; c++) begin
                int x;
                x = ref_dec(e, c);
                wr(REG, 16'hC000 | 16'(e << 6) | 16'(c), 2'b11);
                if (e != 0) chk("R5", last_op, x);
                else        chk("R6", last_op, x);
                chk("R4", last_req, (x != 0) ? 1 : 0);
                if (x != 0) pulse_done();
            end
        end

        // system reset clears only the fields
        wr(REG, 16'h6000, 2'b10);
        rd(REG, rv); chk("R2", int'(rv), 16'h604F);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        rd(REG, rv); chk("R2", int'(rv), 16'h6000);

        // high lane write leaves low byte fields untouched
        wr(REG, 16'h40FF, 2'b10);
        rd(REG, rv); chk("R13", int'(rv), 16'h4000);

        // power-on reset mid-run
        @(negedge clk); por_n = 1'b0;
        rd(REG, rv); chk("R2", int'(rv), 0);
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        rd(REG, rv); chk("R2", int'(rv), 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule